// File: doc/BRIEF.md
# Frame-Pulse Stereo Audio Serial Transmitter

This block sends stereo samples over a serial audio link in which a short frame pulse marks the start of each sample period. One bit goes out per bit-clock period. The left word goes first, most significant bit first, and the right word follows it with no gap. After the right word the line stays low until the next frame. The block runs in the system clock domain. A one-cycle strobe, `bitTick`, marks each bit-clock falling edge. The data output changes only on those strobes, so it is steady when the receiver samples it on the following rising edge.

Samples arrive as a left/right pair on a valid/ready handshake and wait in a one-pair holding slot. As frame master, the block drives a frame pulse one bit period wide, and the spacing between pulses is set in bit periods. As frame slave, it follows the rising edge of an external pulse of any width. In slave mode it raises a sticky error flag when the pulse is malformed or arrives too early.

Top module: `dsp_audio_tx`

## Requirements
- R1: In master mode `fsOut` is high for exactly one bit period, and it rises again once every P bit periods. P is the effective frame period.
- R2: The left MSB is driven during the bit period right after the period in which the frame pulse is sampled high on its rising edge. This is the second bit-clock rising edge after the pulse edge.
- R3: Each word is sent MSB first and is n bits long. The right word's MSB follows the left word's LSB in the next bit period.
- R4: `wordSel` encodes n as 0=16, 1=20, 2=24, 3=32. Each word is taken from the top n bits of its 32-bit input, and the lower bits have no effect on `sdOut`.
- R5: If `framePeriod` is below 2n+1, the effective master period is 2n+1. Otherwise it equals `framePeriod`.
- R6: From the period after the right LSB until the next frame's MSB, `sdOut` is low.
- R7: If no sample pair is held when a frame starts, that frame sends all zeros and `underrun` is high for one clock cycle.
- R8: In slave mode a rising edge of `fsIn`, sampled at the bit strobes, starts a frame whatever the pulse width. `fsOut` stays low.
- R9: In slave mode a rising edge seen after fewer than two low samples of `fsIn` sets `frameErr`. `frameErr` stays set until reset.
- R10: In slave mode a rising edge seen before all 2n bits of the current frame have been sent sets `frameErr`, and the new frame starts at once with the held sample.
- R11: `sdOut` changes only in the clock cycle after a `bitTick` strobe.
- R12: `sampleReady` is high exactly when the holding slot is empty. A pair is taken when `sampleValid` and `sampleReady` are both high, and the slot is emptied when a frame loads the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle strobe at each bit-clock falling edge |
| masterMode | input | 1 | 1 = drive frame pulse, 0 = follow `fsIn` |
| wordSel | input | 2 | Word length select (R4) |
| framePeriod | input | PW | Master frame period in bit periods |
| sampleValid | input | 1 | Sample pair offered |
| sampleLeft | input | SW | Left sample, left-aligned |
| sampleRight | input | SW | Right sample, left-aligned |
| sampleReady | output | 1 | Holding slot empty |
| fsIn | input | 1 | External frame pulse (slave mode) |
| fsOut | output | 1 | Generated frame pulse (master mode) |
| sdOut | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: frame started without data |
| frameErr | output | 1 | Sticky slave framing error |

## Verification
The bench builds the block with SW=32 and PW=8. An 8-bit period field is wide enough to request periods both below and above the 2n+1 floor for every word length. With these values the bench reaches the clamp to 65 periods at n=32, an unclamped 40-period master frame at n=16, and slave frames at n=20 and n=24 whose input low bits are non-zero. It also reaches the two slave error cases: a one-period low gap at the end of a full-length pulse, and a rising edge that arrives mid-word.

// File: rtl/dsp_tx_pkg.sv
package dsp_tx_pkg;
  typedef struct packed {
    logic load;   // frame start: load a held pair or zeros
    logic shift;  // advance one bit
  } pathCmd_t;
endpackage

// File: rtl/ds_frame_ctrl.sv
module ds_frame_ctrl
  import dsp_tx_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  input  logic          masterMode,
  input  logic [CW-1:0] wordLen,
  input  logic [PW-1:0] framePeriod,
  input  logic          fsIn,
  output logic          fsOut,
  output pathCmd_t      cmd,
  output logic          frameErr
);
  localparam int LW = ((PW > CW) ? PW : CW) + 1;

  logic [CW-1:0] twoN;
  logic [LW-1:0] minPeriod, effPeriod, cnt;
  logic [CW-1:0] bitsSent;
  logic [1:0]    lowRun;
  logic          prevFs, rise, startNow, spacingBad, earlyBad;

  assign twoN      = {wordLen[CW-2:0], 1'b0};
  assign minPeriod = LW'(twoN) + LW'(1);
  assign effPeriod = (LW'(framePeriod) < minPeriod) ? minPeriod : LW'(framePeriod);

  assign fsOut      = masterMode && (cnt == '0);
  assign rise       = fsIn && !prevFs;
  assign startNow   = bitTick && (masterMode ? (cnt == '0) : rise);
  assign spacingBad = bitTick && !masterMode && rise && (lowRun < 2'd2);
  assign earlyBad   = bitTick && !masterMode && rise && (bitsSent < twoN);

  assign cmd.load  = startNow;
  assign cmd.shift = bitTick && !startNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      prevFs   <= 1'b0;
      lowRun   <= 2'd2;
      bitsSent <= '1;
      frameErr <= 1'b0;
    end else begin
      if (bitTick) begin
        prevFs <= fsIn;
        if (fsIn)                 lowRun <= 2'd0;
        else if (lowRun != 2'd2)  lowRun <= lowRun + 2'd1;

        if (!masterMode)                    cnt <= '0;
        else if (cnt >= effPeriod - LW'(1)) cnt <= '0;
        else                                cnt <= cnt + LW'(1);

        if (startNow)             bitsSent <= CW'(1);
        else if (bitsSent < twoN) bitsSent <= bitsSent + CW'(1);
      end
      if (spacingBad || earlyBad) frameErr <= 1'b1;
    end
  end
endmodule

// File: rtl/ds_shift_path.sv
module ds_shift_path
  import dsp_tx_pkg::*;
#(
  parameter int SW = 32,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCmd_t      cmd,
  input  logic [CW-1:0] wordLen,
  input  logic          sampleValid,
  input  logic [SW-1:0] sampleLeft,
  input  logic [SW-1:0] sampleRight,
  output logic          sampleReady,
  output logic          sdOut,
  output logic          underrun
);
  localparam int FW = 2 * SW;

  logic          held, take;
  logic [SW-1:0] holdL, holdR, keepMask;
  logic [FW-1:0] shReg, framed;

  assign sampleReady = !held;
  assign take        = sampleValid && !held;
  assign keepMask    = ~({SW{1'b1}} >> wordLen);
  assign framed      = {holdL & keepMask, {SW{1'b0}}}
                     | ({holdR & keepMask, {SW{1'b0}}} >> wordLen);
  assign sdOut       = shReg[FW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held     <= 1'b0;
      holdL    <= '0;
      holdR    <= '0;
      shReg    <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= cmd.load && !held;
      if (take) begin
        held  <= 1'b1;
        holdL <= sampleLeft;
        holdR <= sampleRight;
      end else if (cmd.load) begin
        held <= 1'b0;
      end
      if (cmd.load)       shReg <= held ? framed : '0;
      else if (cmd.shift) shReg <= {shReg[FW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dsp_audio_tx.sv
module dsp_audio_tx
  import dsp_tx_pkg::*;
#(
  parameter int SW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitTick,
  input  logic          masterMode,
  input  logic [1:0]    wordSel,
  input  logic [PW-1:0] framePeriod,
  input  logic          sampleValid,
  input  logic [SW-1:0] sampleLeft,
  input  logic [SW-1:0] sampleRight,
  output logic          sampleReady,
  input  logic          fsIn,
  output logic          fsOut,
  output logic          sdOut,
  output logic          underrun,
  output logic          frameErr
);
  localparam int CW = $clog2(2 * SW + 1);

  pathCmd_t      cmd;
  logic [CW-1:0] wordLen;

  always_comb begin
    case (wordSel)
      2'd0:    wordLen = CW'(16);
      2'd1:    wordLen = CW'(20);
      2'd2:    wordLen = CW'(24);
      default: wordLen = CW'(32);
    endcase
  end

  ds_frame_ctrl #(.PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .masterMode(masterMode),
    .wordLen(wordLen), .framePeriod(framePeriod), .fsIn(fsIn),
    .fsOut(fsOut), .cmd(cmd), .frameErr(frameErr)
  );

  ds_shift_path #(.SW(SW), .CW(CW)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wordLen(wordLen),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleReady(sampleReady), .sdOut(sdOut), .underrun(underrun)
  );
endmodule

// File: rtl/dsp_tx_checker.sv
module dsp_tx_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic masterMode,
  input logic fsOut,
  input logic sdOut,
  input logic underrun,
  input logic frameErr,
  input logic sampleValid,
  input logic sampleReady
);
  // R1
  pulse_one_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsOut && bitTick) |=> !fsOut);
  // R8
  slave_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> !fsOut);
  // R11
  data_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(sdOut));
  // R7
  underrun_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> !underrun);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  // R12
  slot_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady);
endmodule

bind dsp_audio_tx dsp_tx_checker u_chk (.*);

// File: tb/dsp_audio_tx_bench.sv
module dsp_audio_tx_bench;
  logic        clk = 0, rstN = 0, bitTick = 0, masterMode = 0;
  logic [1:0]  wordSel = 0;
  logic [7:0]  framePeriod = 8'd40;
  logic        sampleValid = 0, fsIn = 0;
  logic [31:0] sampleLeft = 0, sampleRight = 0;
  logic        sampleReady, fsOut, sdOut, underrun, frameErr;
  logic        tickEn = 0;
  logic [1:0]  tickPhase = 0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dsp_audio_tx #(.SW(32), .PW(8)) u_dsp_audio_tx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .masterMode(masterMode),
    .wordSel(wordSel), .framePeriod(framePeriod), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .sampleReady(sampleReady),
    .fsIn(fsIn), .fsOut(fsOut), .sdOut(sdOut), .underrun(underrun), .frameErr(frameErr)
  );

  initial forever begin
    @(negedge clk);
    if (!tickEn) tickPhase = 0;
    else tickPhase = tickPhase + 2'd1;
    bitTick = tickEn && (tickPhase == 2'd3);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [31:0] l, input logic [31:0] r, input int n, input int k);
    if (k >= 1 && k <= n)          return l[32-k];
    else if (k > n && k <= 2 * n)  return r[32-(k-n)];
    else                           return 1'b0;
  endfunction

  task automatic doReset(input logic m, input logic [1:0] ws, input logic [7:0] per);
    tickEn = 0; fsIn = 0; sampleValid = 0;
    @(negedge clk);
    rstN = 0; masterMode = m; wordSel = ws; framePeriod = per;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic offer(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    sampleLeft = l; sampleRight = r; sampleValid = 1;
    while (!sampleReady) @(negedge clk);
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic step(input logic fsV);
    fsIn = fsV;
    do @(posedge clk); while (!bitTick);
    #1;
  endtask

  task automatic testReset();
    doReset(0, 0, 8'd40);
    @(negedge clk);
    chk(sdOut == 0 && fsOut == 0 && frameErr == 0 && underrun == 0, "R6 reset outputs", {sdOut, fsOut, frameErr, underrun}, 0);
    chk(sampleReady == 1, "R12 ready after reset", sampleReady, 1);
  endtask

  task automatic testMaster();
    logic [31:0] l = 32'hA5C3_1234, r = 32'h3C96_8765;
    logic keep;
    doReset(1, 0, 8'd40);
    offer(l, r);
    chk(sampleReady == 0, "R12 slot full", sampleReady, 0);
    chk(fsOut == 1, "R1 pulse in period 0", fsOut, 1);
    tickEn = 1;
    for (int k = 1; k <= 81; k++) begin
      step(0);
      if (fsOut != (k % 40 == 0)) chk(0, "R1 pulse spacing", fsOut, (k % 40 == 0));
      if (k < 40 && sdOut != expBit(l, r, 16, k)) chk(0, "R3 master bit", k, expBit(l, r, 16, k));
      if (k > 41 && sdOut != 0) chk(0, "R7 zero frame", sdOut, 0);
      if (k == 1) begin
        chk(sdOut == l[31], "R2 MSB after pulse", sdOut, l[31]);
        chk(underrun == 0, "R7 no underrun with data", underrun, 0);
        chk(sampleReady == 1, "R12 slot emptied on load", sampleReady, 1);
      end
      if (k == 5) begin
        keep = sdOut;
        repeat (2) @(posedge clk);
        #1 chk(sdOut == keep, "R11 steady between strobes", sdOut, keep);
      end
      if (k == 34) chk(sdOut == 0, "R6 idle after right LSB", sdOut, 0);
      if (k == 41) chk(underrun == 1, "R7 underrun pulse", underrun, 1);
    end
    chk(1, "R1 master sequence done", 0, 0);
  endtask

  task automatic testClamp();
    logic [31:0] l = 32'hF00D_BEEF, r = 32'h1357_9BDF;
    int errs = 0;
    doReset(1, 3, 8'd10);
    offer(l, r);
    tickEn = 1;
    for (int k = 1; k <= 66; k++) begin
      step(0);
      if (k <= 65 && fsOut != (k == 65)) errs++;
      if (k <= 64 && sdOut != expBit(l, r, 32, k)) errs++;
    end
    chk(errs == 0, "R5 R4 clamp to 65 with 32-bit words", errs, 0);
  endtask

  task automatic testSlave();
    logic [31:0] l = 32'h8ABC_DEFF, r = 32'h7135_7FFF;
    logic [31:0] l2 = 32'hC000_0000, r2 = 32'h0;
    int errs = 0;
    doReset(0, 1, 8'd40);
    offer(l, r);
    tickEn = 1;
    step(0);
    chk(sdOut == 0 && fsOut == 0, "R8 idle before pulse", {sdOut, fsOut}, 0);
    for (int k = 0; k < 60; k++) begin
      step(k < 3);
      if (k == 0) offer(l2, r2);
      if (sdOut != expBit(l, r, 20, k + 1)) errs++;
      if (fsOut) errs++;
    end
    chk(errs == 0, "R4 R8 R6 slave 20-bit frame, wide pulse", errs, 0);
    step(1);
    chk(sdOut == 1, "R8 second frame MSB", sdOut, 1);
    step(1);
    chk(sdOut == 1, "R8 second frame bit 2", sdOut, 1);
    chk(frameErr == 0, "R9 no error on legal pulses", frameErr, 0);
  endtask

  task automatic testSpacing();
    logic [31:0] l = 32'hDEAD_BEEF, r = 32'hCAFE_F00D;
    doReset(0, 2, 8'd40);
    offer(l, r);
    tickEn = 1;
    for (int k = 0; k <= 48; k++) step(1);
    step(0);
    chk(frameErr == 0, "R9 no error before bad edge", frameErr, 0);
    step(1);
    chk(frameErr == 1, "R9 short low gap flagged", frameErr, 0 + 1);
    for (int k = 0; k < 5; k++) step(0);
    chk(frameErr == 1, "R9 error is sticky", frameErr, 1);
  endtask

  task automatic testEarly();
    logic [31:0] l = 32'h5A5A_0000, r = 32'h0;
    logic [31:0] l2 = 32'hC3A5_0000, r2 = 32'h0;
    int errs = 0;
    doReset(0, 0, 8'd40);
    offer(l, r);
    tickEn = 1;
    step(1);
    offer(l2, r2);
    for (int k = 1; k <= 4; k++) begin
      step(0);
      if (sdOut != expBit(l, r, 16, k + 1)) errs++;
    end
    chk(errs == 0 && frameErr == 0, "R10 first frame before early edge", errs, 0);
    step(1);
    chk(frameErr == 1, "R10 early edge flagged", frameErr, 1);
    chk(sdOut == l2[31], "R10 restart with new MSB", sdOut, l2[31]);
    errs = 0;
    for (int k = 2; k <= 6; k++) begin
      step(0);
      if (sdOut != expBit(l2, r2, 16, k)) errs++;
    end
    chk(errs == 0, "R10 restarted word bits", errs, 0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testMaster();
    testClamp();
    testSlave();
    testSpacing();
    testEarly();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule